// File: doc/BRIEF.md
# Unlock-Cycle NOR Flash Command Sequencer

This block drives a parallel NOR flash bank that speaks the unlock-cycle command dialect. A client hands it one request at a time: program a word, erase a sector, or fetch the identifier codes. The sequencer then issues every bus cycle the device needs. Each command begins with a two-write unlock preamble placed at fixed word offsets above the bank base. The sequencer then watches bit 7 of the read-back data to tell when the device has finished, and returns a completion code. For identifier requests it also returns the manufacturer and device words.

The flash data bus is a parameter number of byte lanes wide. Every command byte is copied into all lanes, so several byte-wide devices side by side are driven as one. The bus is a simple synchronous port. A write strobe carries the address and data in the same cycle. A read strobe is answered on the read-data input in the following cycle. The program and erase timeouts, and the settle time before erase polling starts, are all counted in clock cycles.

Top module: `nor_unlock_seq`

## Requirements
- R1: After reset the block shows ready high, done low, and neither bus strobe active.
- R2: A program request (op code 0) writes 0xAA at base+0x555, then 0x55 at base+0x2AA, then 0xA0 at base+0x555, then the data word at the destination. Every command byte is copied into each byte lane.
- R3: Before any write cycle, a program request reads the destination once. If the request needs any bit to go from 0 to 1, it ends with code 2 and makes no write cycle. Codes are: 0 success, 1 timeout, 2 not erased.
- R4: Program polling reads the destination until bit 7 of every lane equals bit 7 of the same lane in the data word, then ends with code 0.
- R5: If program polling does not finish within the program timeout, the block writes 0xF0 to the destination and ends with code 1.
- R6: A sector erase (op code 1) makes exactly six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, and finally 0x30 at the sector address.
- R7: After the last erase write, no read happens for at least the configured settle time.
- R8: Erase polling ends with code 0 only once bit 7 reads 1 in every lane.
- R9: If erase polling does not finish within the erase timeout, the block writes 0xF0 to the sector address and ends with code 1.
- R10: An identifier request (op code 2) writes the preamble and then 0x90@0x555. It reads base+0 and returns that word's low byte as the manufacturer code. It reads base+1 and returns that whole word as the device code. It then writes 0xF0 at the base and ends with code 0.
- R11: The block ignores a request while it is busy, and ignores op code 3 at any time. Each accepted request produces exactly one single-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when ready |
| req_op_i | input | 2 | 0 program, 1 erase, 2 identifier, 3 ignored |
| req_addr_i | input | ADDR_W | Destination word or sector address |
| req_data_i | input | 8*LANES | Word to program |
| req_ready_o | output | 1 | Idle and able to take a request |
| done_o | output | 1 | One-cycle completion pulse |
| done_code_o | output | 2 | 0 success, 1 timeout, 2 not erased |
| id_manuf_o | output | 8 | Manufacturer code from last identifier read |
| id_device_o | output | 8*LANES | Device word from last identifier read |
| fl_addr_o | output | ADDR_W | Flash word address |
| fl_wdata_o | output | 8*LANES | Flash write data |
| fl_we_o | output | 1 | Flash write strobe |
| fl_re_o | output | 1 | Flash read strobe |
| fl_rdata_i | input | 8*LANES | Flash read data, one cycle after the read strobe |

## Verification
A bus model records every write and returns scripted read values. The scripts cover several cases:
- an erased destination;
- a destination that still holds zeros where the data has ones;
- busy replies that exit polling, then settle.

The program busy reply has the top lane already correct and only the low lane still wrong. This separates a per-lane bit-7 comparison from a check of a single lane or of the whole word. The erase busy reply has only one lane at 1. This separates "all lanes" from "any lane". Endless busy replies reach both timeouts. Identifier replies with distinct bytes in each lane show which byte and which word are returned.

// File: rtl/nor_seq_pkg.sv
// Shared types and command constants for the unlock-cycle flash sequencer.
// Assumes byte-wide devices; commands are byte values copied into each lane.
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_ERASE  = 2'd1,
        OP_READID = 2'd2,
        OP_NONE   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        TGT_UNLK_HI = 2'd0,   // base + 0x555
        TGT_UNLK_LO = 2'd1,   // base + 0x2AA
        TGT_REQ     = 2'd2    // requested destination or sector
    } tgt_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE_RD,
        S_PRE_EV,
        S_CMD,
        S_SETTLE,
        S_POLL_RD,
        S_POLL_EV,
        S_ID_RD,
        S_ID_EV,
        S_RESET,
        S_DONE
    } state_e;

    localparam logic [1:0] CODE_OK         = 2'd0;
    localparam logic [1:0] CODE_TIMEOUT    = 2'd1;
    localparam logic [1:0] CODE_NOT_ERASED = 2'd2;

    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_READ    = 8'hF0;

endpackage

// File: rtl/nor_step_table.sv
// Command step table: for an operation and a step index, gives the target
// address kind, the command byte, whether the request data is written
// instead, and whether this is the last write of the sequence.
// Assumes the step index never passes the last step of the operation.
module nor_step_table
    import nor_seq_pkg::*;
(
    input  op_e        op_i,
    input  logic [2:0] step_i,
    output tgt_e       tgt_o,
    output logic [7:0] byte_o,
    output logic       use_data_o,
    output logic       last_o
);

    // Decode one step of the selected operation.
    always_comb begin
        tgt_o      = TGT_UNLK_HI;
        byte_o     = CMD_KEY1;
        use_data_o = 1'b0;
        last_o     = 1'b0;
        unique case (step_i)
            3'd0: begin tgt_o = TGT_UNLK_HI; byte_o = CMD_KEY1; end
            3'd1: begin tgt_o = TGT_UNLK_LO; byte_o = CMD_KEY2; end
            3'd2: begin
                tgt_o = TGT_UNLK_HI;
                case (op_i)
                    OP_PROG:  byte_o = CMD_PROGRAM;
                    OP_ERASE: byte_o = CMD_ERASE;
                    default:  begin byte_o = CMD_IDENT; last_o = 1'b1; end
                endcase
            end
            3'd3: begin
                if (op_i == OP_PROG) begin
                    tgt_o      = TGT_REQ;
                    use_data_o = 1'b1;
                    last_o     = 1'b1;
                end else begin
                    tgt_o  = TGT_UNLK_HI;
                    byte_o = CMD_KEY1;
                end
            end
            3'd4: begin tgt_o = TGT_UNLK_LO; byte_o = CMD_KEY2; end
            3'd5: begin tgt_o = TGT_REQ; byte_o = CMD_SECTOR; last_o = 1'b1; end
            default: begin last_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/nor_poll_judge.sv
// Completion test on a polled word. Program mode: bit 7 of every lane must
// equal bit 7 of the same lane of the reference word. Erase mode: bit 7 of
// every lane must be 1.
module nor_poll_judge #(
    parameter int LANES = 2,
    localparam int DW   = 8 * LANES
) (
    input  logic          erase_mode_i,
    input  logic [DW-1:0] rdata_i,
    input  logic [DW-1:0] ref_i,
    output logic          hit_o
);

    logic [LANES-1:0] lane_ok;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Per-lane bit-7 comparison.
        assign lane_ok[l] = erase_mode_i ? rdata_i[8*l+7]
                                         : (rdata_i[8*l+7] == ref_i[8*l+7]);
    end

    assign hit_o = &lane_ok;

endmodule

// File: rtl/nor_wait_timer.sv
// Down-counter shared by the settle wait and the polling timeouts.
// Load has priority over decrement; callers only decrement a nonzero count.
module nor_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    input  logic          dec_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_q;

    // Count register: load, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R5 R9: a timeout window may not wrap below zero
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (cnt_q != '0));

endmodule

// File: rtl/nor_unlock_seq.sv
// Unlock-cycle NOR flash sequencer. Takes program, sector-erase and
// identifier requests, issues the unlock preamble and command writes,
// polls bit 7 for completion, and reports a result code.
// Assumes a bus where a read strobe is answered one cycle later, and one
// request in flight at a time.
module nor_unlock_seq
    import nor_seq_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter int          LANES       = 2,
    parameter int unsigned BANK_BASE   = 0,
    parameter int unsigned PROG_TOUT   = 4096,
    parameter int unsigned ERASE_TOUT  = 250_000_000,
    parameter int unsigned ERASE_SETTLE = 250_000,
    localparam int         DW          = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DW-1:0]     req_data_i,
    output logic              req_ready_o,
    output logic              done_o,
    output logic [1:0]        done_code_o,
    output logic [7:0]        id_manuf_o,
    output logic [DW-1:0]     id_device_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [DW-1:0]     fl_wdata_o,
    output logic              fl_we_o,
    output logic              fl_re_o,
    input  logic [DW-1:0]     fl_rdata_i
);

    localparam int unsigned MAX_A = (PROG_TOUT > ERASE_TOUT) ? PROG_TOUT : ERASE_TOUT;
    localparam int unsigned MAX_W = (MAX_A > ERASE_SETTLE) ? MAX_A : ERASE_SETTLE;
    localparam int TW = $clog2(MAX_W + 1);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BANK_BASE);
    localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(BANK_BASE + 32'h555);
    localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(BANK_BASE + 32'h2AA);

    state_e            st_q;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     data_q;
    logic [2:0]        step_q;
    logic              id_idx_q;
    logic [1:0]        code_q;
    logic [7:0]        manuf_q;
    logic [DW-1:0]     device_q;

    tgt_e       tbl_tgt;
    logic [7:0] tbl_byte;
    logic       tbl_use_data;
    logic       tbl_last;

    logic          poll_hit;
    logic          tmr_zero;
    logic          tmr_load;
    logic          tmr_dec;
    logic [TW-1:0] tmr_val;
    logic          not_erased;

    nor_step_table u_steps (
        .op_i       (op_q),
        .step_i     (step_q),
        .tgt_o      (tbl_tgt),
        .byte_o     (tbl_byte),
        .use_data_o (tbl_use_data),
        .last_o     (tbl_last)
    );

    nor_poll_judge #(.LANES(LANES)) u_judge (
        .erase_mode_i (op_q == OP_ERASE),
        .rdata_i      (fl_rdata_i),
        .ref_i        (data_q),
        .hit_o        (poll_hit)
    );

    nor_wait_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .dec_i      (tmr_dec),
        .zero_o     (tmr_zero)
    );

    // A program would need a 0 bit raised to 1.
    assign not_erased = ((fl_rdata_i & data_q) != data_q);

    // Timer control: which window to open and when to count down.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        unique case (st_q)
            S_CMD: if (tbl_last && op_q != OP_READID) begin
                tmr_load = 1'b1;
                tmr_val  = (op_q == OP_PROG) ? TW'(PROG_TOUT) : TW'(ERASE_SETTLE);
            end
            S_SETTLE: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(ERASE_TOUT);
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            S_POLL_RD: tmr_dec = !tmr_zero;
            S_POLL_EV: tmr_dec = !poll_hit && !tmr_zero;
            default: ;
        endcase
    end

    // Main sequencing state machine and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            op_q     <= OP_PROG;
            addr_q   <= '0;
            data_q   <= '0;
            step_q   <= '0;
            id_idx_q <= 1'b0;
            code_q   <= CODE_OK;
            manuf_q  <= '0;
            device_q <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (req_valid_i && op_e'(req_op_i) != OP_NONE) begin
                        op_q   <= op_e'(req_op_i);
                        addr_q <= req_addr_i;
                        data_q <= req_data_i;
                        step_q <= '0;
                        st_q   <= (op_e'(req_op_i) == OP_PROG) ? S_PRE_RD : S_CMD;
                    end
                end
                S_PRE_RD: st_q <= S_PRE_EV;
                S_PRE_EV: begin
                    if (not_erased) begin
                        code_q <= CODE_NOT_ERASED;
                        st_q   <= S_DONE;
                    end else begin
                        st_q <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (tbl_last) begin
                        id_idx_q <= 1'b0;
                        unique case (op_q)
                            OP_PROG:  st_q <= S_POLL_RD;
                            OP_ERASE: st_q <= S_SETTLE;
                            default:  st_q <= S_ID_RD;
                        endcase
                    end else begin
                        step_q <= step_q + 3'd1;
                    end
                end
                S_SETTLE: if (tmr_zero) st_q <= S_POLL_RD;
                S_POLL_RD: st_q <= S_POLL_EV;
                S_POLL_EV: begin
                    if (poll_hit) begin
                        code_q <= CODE_OK;
                        st_q   <= S_DONE;
                    end else if (tmr_zero) begin
                        code_q <= CODE_TIMEOUT;
                        st_q   <= S_RESET;
                    end else begin
                        st_q <= S_POLL_RD;
                    end
                end
                S_ID_RD: st_q <= S_ID_EV;
                S_ID_EV: begin
                    if (!id_idx_q) begin
                        manuf_q  <= fl_rdata_i[7:0];
                        id_idx_q <= 1'b1;
                        st_q     <= S_ID_RD;
                    end else begin
                        device_q <= fl_rdata_i;
                        code_q   <= CODE_OK;
                        st_q     <= S_RESET;
                    end
                end
                S_RESET: st_q <= S_DONE;
                S_DONE:  st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Bus drive: address, data and strobes from the current state.
    always_comb begin
        fl_we_o    = 1'b0;
        fl_re_o    = 1'b0;
        fl_addr_o  = BASE_A;
        fl_wdata_o = '0;
        unique case (st_q)
            S_PRE_RD, S_POLL_RD: begin
                fl_re_o   = 1'b1;
                fl_addr_o = addr_q;
            end
            S_CMD: begin
                fl_we_o = 1'b1;
                unique case (tbl_tgt)
                    TGT_UNLK_HI: fl_addr_o = HI_A;
                    TGT_UNLK_LO: fl_addr_o = LO_A;
                    default:     fl_addr_o = addr_q;
                endcase
                fl_wdata_o = tbl_use_data ? data_q : {LANES{tbl_byte}};
            end
            S_ID_RD: begin
                fl_re_o   = 1'b1;
                fl_addr_o = BASE_A + ADDR_W'(id_idx_q);
            end
            S_RESET: begin
                fl_we_o    = 1'b1;
                fl_addr_o  = (op_q == OP_READID) ? BASE_A : addr_q;
                fl_wdata_o = {LANES{CMD_READ}};
            end
            default: ;
        endcase
    end

    assign req_ready_o = (st_q == S_IDLE);
    assign done_o      = (st_q == S_DONE);
    assign done_code_o = code_q;
    assign id_manuf_o  = manuf_q;
    assign id_device_o = device_q;

    // R1: an idle block leaves the bus quiet
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!fl_we_o && !fl_re_o));

    // R2
    lane_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we_o && !(st_q == S_CMD && tbl_use_data))
            |-> (fl_wdata_o == {LANES{fl_wdata_o[7:0]}}));

    // R3
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_PRE_EV && not_erased)
            |=> (done_o && done_code_o == CODE_NOT_ERASED && !fl_we_o));

    // R5 R9: a timeout is always preceded by the read/reset command
    timeout_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && done_code_o == CODE_TIMEOUT)
            |-> ($past(fl_we_o) && $past(fl_wdata_o[7:0]) == CMD_READ));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && req_ready_o));

endmodule

// File: tb/nor_unlock_seq_tb.sv
`timescale 1ns/1ps
module nor_unlock_seq_tb_top;

    localparam int ADDR_W = 16;
    localparam int LANES  = 2;
    localparam int DW     = 16;
    localparam int unsigned BASE   = 32'h1000;
    localparam int unsigned P_TOUT = 30;
    localparam int unsigned E_TOUT = 60;
    localparam int unsigned SETTLE = 25;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DW-1:0]     req_data = '0;
    logic              req_ready, done;
    logic [1:0]        done_code;
    logic [7:0]        id_manuf;
    logic [DW-1:0]     id_device;
    logic [ADDR_W-1:0] fl_addr;
    logic [DW-1:0]     fl_wdata;
    logic              fl_we, fl_re;
    logic [DW-1:0]     fl_rdata = '0;

    nor_unlock_seq #(
        .ADDR_W(ADDR_W), .LANES(LANES), .BANK_BASE(BASE),
        .PROG_TOUT(P_TOUT), .ERASE_TOUT(E_TOUT), .ERASE_SETTLE(SETTLE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_op_i(req_op),
        .req_addr_i(req_addr), .req_data_i(req_data),
        .req_ready_o(req_ready), .done_o(done), .done_code_o(done_code),
        .id_manuf_o(id_manuf), .id_device_o(id_device),
        .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata),
        .fl_we_o(fl_we), .fl_re_o(fl_re), .fl_rdata_i(fl_rdata)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Bus model configuration, set by tasks.
    logic          m_id_mode;
    logic          m_pre_pending;
    int            m_busy_left;
    logic [DW-1:0] m_pre_val, m_busy_val, m_done_val, m_id0, m_id1;
    // Bus model observations.
    int            n_wr, n_rd, last_wr_cyc, first_poll_cyc;
    logic          poll_seen;
    logic [ADDR_W-1:0] log_a [16];
    logic [DW-1:0]     log_d [16];
    logic [ADDR_W-1:0] exp_a [16];
    logic [DW-1:0]     exp_d [16];
    int                exp_n;
    int                done_cnt;

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Flash bus model: logs writes, answers reads one cycle later.
    always @(posedge clk) begin
        if (fl_we) begin
            if (n_wr < 16) begin
                log_a[n_wr] <= fl_addr;
                log_d[n_wr] <= fl_wdata;
            end
            n_wr <= n_wr + 1;
            last_wr_cyc <= cyc;
        end
        if (fl_re) begin
            n_rd <= n_rd + 1;
            if (m_id_mode) begin
                fl_rdata <= (fl_addr == ADDR_W'(BASE)) ? m_id0 : m_id1;
            end else if (m_pre_pending) begin
                fl_rdata <= m_pre_val;
                m_pre_pending <= 1'b0;
            end else begin
                if (!poll_seen) begin
                    poll_seen <= 1'b1;
                    first_poll_cyc <= cyc;
                end
                if (m_busy_left > 0) begin
                    fl_rdata <= m_busy_val;
                    m_busy_left <= m_busy_left - 1;
                end else begin
                    fl_rdata <= m_done_val;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_setup(input logic idm, input logic pre, input int busy,
                               input logic [DW-1:0] pv, input logic [DW-1:0] bv,
                               input logic [DW-1:0] dv);
        @(negedge clk);
        m_id_mode = idm; m_pre_pending = pre; m_busy_left = busy;
        m_pre_val = pv; m_busy_val = bv; m_done_val = dv;
        n_wr = 0; n_rd = 0; poll_seen = 1'b0; done_cnt = 0; exp_n = 0;
    endtask

    task automatic expect_wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n = exp_n + 1;
    endtask

    task automatic chk_log(input string tag);
        chk({tag, " write count"}, n_wr, exp_n);
        for (int i = 0; i < exp_n && i < 16; i++) begin
            chk($sformatf("%s write %0d addr", tag, i), log_a[i], exp_a[i]);
            chk($sformatf("%s write %0d data", tag, i), log_d[i], exp_d[i]);
        end
    endtask

    // Issue one request and wait for its done pulse; leaves time at a negedge with done high.
    task automatic run_req(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                           input logic [DW-1:0] d, input string tag);
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk({tag, " done seen"}, done, 1'b1);
    endtask

    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + 32'h555);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE + 32'h2AA);

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1'b1);
        chk("R1 done low after reset", done, 1'b0);
        chk("R1 no write strobe", fl_we, 1'b0);
        chk("R1 no read strobe", fl_re, 1'b0);
    endtask

    task automatic t_prog_ok();
        // Busy reply: top lane already right, low lane still wrong.
        model_setup(1'b0, 1'b1, 2, 16'hFFFF, 16'h8080, 16'h8000);
        run_req(2'd0, 16'h2040, 16'h8000, "R4");
        chk("R4 code ok", done_code, 2'd0);
        chk("R4 reads incl per-lane busy", n_rd, 4);
        expect_wr(HI, 16'hAAAA); expect_wr(LO, 16'h5555);
        expect_wr(HI, 16'hA0A0); expect_wr(16'h2040, 16'h8000);
        chk_log("R2");
    endtask

    task automatic t_prog_reject();
        model_setup(1'b0, 1'b1, 0, 16'h00FF, 16'h0, 16'h0);
        run_req(2'd0, 16'h2044, 16'h0F0F, "R3");
        chk("R3 code not erased", done_code, 2'd2);
        chk("R3 single read", n_rd, 1);
        chk_log("R3");
    endtask

    task automatic t_prog_timeout();
        model_setup(1'b0, 1'b1, 100000, 16'hFFFF, 16'h00FF, 16'h00FF);
        run_req(2'd0, 16'h2050, 16'h1234, "R5");
        chk("R5 code timeout", done_code, 2'd1);
        expect_wr(HI, 16'hAAAA); expect_wr(LO, 16'h5555);
        expect_wr(HI, 16'hA0A0); expect_wr(16'h2050, 16'h1234);
        expect_wr(16'h2050, 16'hF0F0);
        chk_log("R5");
        chk("R5 polled more than once", (n_rd > 5) ? 1 : 0, 1);
    endtask

    task automatic t_erase_ok();
        model_setup(1'b0, 1'b0, 3, 16'h0, 16'h0080, 16'hFFFF);
        run_req(2'd1, 16'h3000, 16'h0, "R8");
        chk("R8 code ok", done_code, 2'd0);
        chk("R8 reads incl one-lane busy", n_rd, 4);
        chk("R7 settle before first poll",
            ((first_poll_cyc - last_wr_cyc) >= int'(SETTLE)) ? 1 : 0, 1);
        expect_wr(HI, 16'hAAAA); expect_wr(LO, 16'h5555); expect_wr(HI, 16'h8080);
        expect_wr(HI, 16'hAAAA); expect_wr(LO, 16'h5555); expect_wr(16'h3000, 16'h3030);
        chk_log("R6");
    endtask

    task automatic t_erase_timeout();
        model_setup(1'b0, 1'b0, 100000, 16'h0, 16'h7F7F, 16'h7F7F);
        run_req(2'd1, 16'h3800, 16'h0, "R9");
        chk("R9 code timeout", done_code, 2'd1);
        expect_wr(HI, 16'hAAAA); expect_wr(LO, 16'h5555); expect_wr(HI, 16'h8080);
        expect_wr(HI, 16'hAAAA); expect_wr(LO, 16'h5555); expect_wr(16'h3800, 16'h3030);
        expect_wr(16'h3800, 16'hF0F0);
        chk_log("R9");
    endtask

    task automatic t_read_id();
        model_setup(1'b1, 1'b0, 0, 16'h0, 16'h0, 16'h0);
        m_id0 = 16'h3301; m_id1 = 16'h22D7;
        run_req(2'd2, 16'h0000, 16'h0, "R10");
        chk("R10 code ok", done_code, 2'd0);
        chk("R10 manufacturer low byte", id_manuf, 8'h01);
        chk("R10 device word", id_device, 16'h22D7);
        chk("R10 two reads", n_rd, 2);
        expect_wr(HI, 16'hAAAA); expect_wr(LO, 16'h5555);
        expect_wr(HI, 16'h9090); expect_wr(ADDR_W'(BASE), 16'hF0F0);
        chk_log("R10");
    endtask

    task automatic t_ignore();
        // Op code 3 while idle: nothing happens.
        model_setup(1'b0, 1'b0, 0, 16'h0, 16'h0, 16'hFFFF);
        req_op = 2'd3; req_addr = 16'h4000; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk("R11 op3 no writes", n_wr, 0);
        chk("R11 op3 no done", done_cnt, 0);
        chk("R11 op3 still ready", req_ready, 1'b1);
        // Erase request held high during a program: only the program runs.
        model_setup(1'b0, 1'b1, 0, 16'hFFFF, 16'h0, 16'h0055);
        req_op = 2'd0; req_addr = 16'h2060; req_data = 16'h0055; req_valid = 1'b1;
        @(negedge clk);
        req_op = 2'd1; req_addr = 16'h3000;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk("R11 program code", done_code, 2'd0);
        repeat (20) @(negedge clk);
        chk("R11 single done pulse", done_cnt, 1);
        expect_wr(HI, 16'hAAAA); expect_wr(LO, 16'h5555);
        expect_wr(HI, 16'hA0A0); expect_wr(16'h2060, 16'h0055);
        chk_log("R11");
    endtask

    initial begin
        m_id_mode = 0; m_pre_pending = 0; m_busy_left = 0;
        m_pre_val = '0; m_busy_val = '0; m_done_val = '0; m_id0 = '0; m_id1 = '0;
        n_wr = 0; n_rd = 0; poll_seen = 0; done_cnt = 0; exp_n = 0;
        last_wr_cyc = 0; first_poll_cyc = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prog_ok();
        t_prog_reject();
        t_prog_timeout();
        t_erase_ok();
        t_erase_timeout();
        t_read_id();
        t_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule